// File: doc/BRIEF.md
# Pin Data and Direction Register Bank

This block holds the output data, the direction and the pull control of a bank of general-purpose pins, 32 by default. Software changes single pins without a read-modify-write: the output data and the direction each have a pair of write ports. One port sets the bits written as 1 and the other clears them. Bits written as 0 leave their pins alone. A separate word turns the pull resistor off for each pin. While the pull is on, its direction comes from the pin's output data bit: a 1 gives a pull-up and a 0 gives a pull-down.

Two write channels reach the bank in the same cycle, so two agents can update it without arbitration. Pad inputs pass through a two-flop synchroniser, and the synchronised levels are read back through the registered read port. The pad control outputs go straight to the pad ring.

Top module: `gpio_bank`

## Requirements
- R1: In every cycle after reset is released, before any write, all pins are inputs (pad_oe = 0), pad_out = 0, every pull is off (pad_pull_en = 0) and rd_data = 0.
- R2: A write to address 1 sets every output data bit whose write-data bit is 1. Bits written as 0 keep their value. The change shows on pad_out on the clock edge that takes the write.
- R3: A write to address 2 clears every output data bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to address 3 sets direction bits and a write to address 4 clears them, using the same write-one rule. A direction bit of 1 makes the pin an output, and pad_oe equals the direction word.
- R5: When the same bit is set and cleared in one cycle, the clear wins. This holds whether the two requests come on one channel in turn or on the two channels together.
- R6: A write to address 5 loads the pull-off word. A 1 turns that pin's pull off, so pad_pull_en is the inverse of this word. If both channels write address 5 in the same cycle, channel B's data is stored.
- R7: pad_pull_up equals the output data bit of each pin. Changing the data of an output pin therefore also changes its pull direction.
- R8: Reading address 0 returns the pad levels through a two-flop synchroniser. A pad change made before clock edge k shows on rd_data after edge k+2.
- R9: rd_data is registered one cycle after rd_addr is presented. Addresses 1, 2 and 6 return the output data, addresses 3, 4 and 7 return the direction, and address 5 returns the pull-off word.
- R10: Writes to address 0 (and any write with we low) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_we | input | 1 | Write strobe, channel A |
| a_addr | input | 3 | Register address, channel A |
| a_wdata | input | 32 | Write data, channel A |
| b_we | input | 1 | Write strobe, channel B |
| b_addr | input | 3 | Register address, channel B |
| b_wdata | input | 32 | Write data, channel B |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Output enable per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction, 1 = up |

## Verification
Set and clear words with overlapping and disjoint bit patterns show whether 0 bits are left alone and whether each port touches only its own register. Same-cycle conflicts, both within one register pair and across the two channels, separate clear-wins from set-wins and from last-channel-wins. Pad patterns that change while address 0 is read pin down the exact synchroniser delay. Toggling output data with the pull on shows the pull direction following the data bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        RA_PIN      = 3'd0,
        RA_OUT_SET  = 3'd1,
        RA_OUT_CLR  = 3'd2,
        RA_DIR_SET  = 3'd3,
        RA_DIR_CLR  = 3'd4,
        RA_PULL_OFF = 3'd5,
        RA_OUT_VAL  = 3'd6,
        RA_DIR_VAL  = 3'd7
    } gpio_reg_e;

    function automatic logic addr_hit(input logic we,
                                      input logic [GPIO_ADDR_W-1:0] addr,
                                      input gpio_reg_e target);
        return we && (addr == target);
    endfunction

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   a_we,
    input  logic [GPIO_ADDR_W-1:0] a_addr,
    input  logic [W-1:0]           a_wdata,
    input  logic                   b_we,
    input  logic [GPIO_ADDR_W-1:0] b_addr,
    input  logic [W-1:0]           b_wdata,
    output logic [W-1:0]           out_set,
    output logic [W-1:0]           out_clr,
    output logic [W-1:0]           dir_set,
    output logic [W-1:0]           dir_clr,
    output logic                   poff_we,
    output logic [W-1:0]           poff_wdata
);
    logic a_poff, b_poff;

    always_comb begin
        out_set = ({W{addr_hit(a_we, a_addr, RA_OUT_SET)}} & a_wdata)
                | ({W{addr_hit(b_we, b_addr, RA_OUT_SET)}} & b_wdata);
        out_clr = ({W{addr_hit(a_we, a_addr, RA_OUT_CLR)}} & a_wdata)
                | ({W{addr_hit(b_we, b_addr, RA_OUT_CLR)}} & b_wdata);
        dir_set = ({W{addr_hit(a_we, a_addr, RA_DIR_SET)}} & a_wdata)
                | ({W{addr_hit(b_we, b_addr, RA_DIR_SET)}} & b_wdata);
        dir_clr = ({W{addr_hit(a_we, a_addr, RA_DIR_CLR)}} & a_wdata)
                | ({W{addr_hit(b_we, b_addr, RA_DIR_CLR)}} & b_wdata);
        a_poff     = addr_hit(a_we, a_addr, RA_PULL_OFF);
        b_poff     = addr_hit(b_we, b_addr, RA_PULL_OFF);
        poff_we    = a_poff | b_poff;
        poff_wdata = b_poff ? b_wdata : a_wdata;
    end

    // R10: with no strobe, no mask may be active
    p_idle_no_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (!a_we && !b_we) |-> (out_set == '0 && out_clr == '0 &&
                              dir_set == '0 && dir_clr == '0 && !poff_we));

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= (q | set_mask) & ~clr_mask;
    end

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((q & $past(clr_mask)) == '0));

    p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
        ((set_mask & ~clr_mask) != '0) |=>
        ((q & ($past(set_mask) & ~$past(clr_mask))) == ($past(set_mask) & ~$past(clr_mask))));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0 && clr_mask == '0) |=> (q == $past(q)));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage[s] <= '0;
                else if (s == 0) stage[s] <= din;
                else             stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];

    logic [1:0] aged;
    always_ff @(posedge clk) begin
        if (rst) aged <= '0;
        else     aged <= {aged[0], 1'b1};
    end

    p_sync_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (STAGES == 2 && aged[1]) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W = 32
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] poff_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pull_en,
    output logic [W-1:0] pad_pull_up
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            assign pad_out[i]     = out_q[i];
            assign pad_oe[i]      = dir_q[i];
            assign pad_pull_en[i] = ~poff_q[i];
            assign pad_pull_up[i] = out_q[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   a_we,
    input  logic [GPIO_ADDR_W-1:0] a_addr,
    input  logic [W-1:0]           a_wdata,
    input  logic                   b_we,
    input  logic [GPIO_ADDR_W-1:0] b_addr,
    input  logic [W-1:0]           b_wdata,
    input  logic [GPIO_ADDR_W-1:0] rd_addr,
    output logic [W-1:0]           rd_data,
    input  logic [W-1:0]           pad_in,
    output logic [W-1:0]           pad_out,
    output logic [W-1:0]           pad_oe,
    output logic [W-1:0]           pad_pull_en,
    output logic [W-1:0]           pad_pull_up
);
    logic [W-1:0] out_set, out_clr, dir_set, dir_clr;
    logic         poff_we;
    logic [W-1:0] poff_wdata;
    logic [W-1:0] out_q, dir_q, poff_q, pin_sync;

    gpio_wr_decode #(.W(W)) u_dec (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .out_set(out_set), .out_clr(out_clr),
        .dir_set(dir_set), .dir_clr(dir_clr),
        .poff_we(poff_we), .poff_wdata(poff_wdata)
    );

    gpio_setclr_reg #(.W(W), .RST_VAL('0)) u_out (
        .clk(clk), .rst(rst), .set_mask(out_set), .clr_mask(out_clr), .q(out_q)
    );

    gpio_setclr_reg #(.W(W), .RST_VAL('0)) u_dir (
        .clk(clk), .rst(rst), .set_mask(dir_set), .clr_mask(dir_clr), .q(dir_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          poff_q <= '1;
        else if (poff_we) poff_q <= poff_wdata;
    end

    gpio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(pin_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else begin
            case (gpio_reg_e'(rd_addr))
                RA_PIN:                            rd_data <= pin_sync;
                RA_OUT_SET, RA_OUT_CLR, RA_OUT_VAL: rd_data <= out_q;
                RA_DIR_SET, RA_DIR_CLR, RA_DIR_VAL: rd_data <= dir_q;
                RA_PULL_OFF:                       rd_data <= poff_q;
                default:                           rd_data <= '0;
            endcase
        end
    end

    gpio_pad_ctrl #(.W(W)) u_pad (
        .out_q(out_q), .dir_q(dir_q), .poff_q(poff_q),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && pad_pull_en == '0));

    p_pin_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (a_we && a_addr == RA_PIN && !b_we) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pull_en)));

    p_pull_b_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (b_we && b_addr == RA_PULL_OFF) |=> (pad_pull_en == ~$past(b_wdata)));

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a_we = 1'b0, b_we = 1'b0;
    logic [2:0]   a_addr = '0, b_addr = '0, rd_addr = '0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0, pad_in = '0;
    logic [W-1:0] rd_data, pad_out, pad_oe, pad_pull_en, pad_pull_up;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    gpio_bank #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    always #5 clk = ~clk;

    // Behavioural reference
    logic [W-1:0] m_out = '0, m_dir = '0, m_poff = '1, m_rd = '0;
    logic [W-1:0] hist[$] = '{'0, '0};

    function automatic logic [W-1:0] pick(logic we, logic [2:0] ad, logic [W-1:0] d, int target);
        return (we && ad == target) ? d : '0;
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] s_o, c_o, s_d, c_d;
        cycles++;
        if (rst) begin
            m_out = '0; m_dir = '0; m_poff = '1; m_rd = '0;
            hist.push_front('0);
        end else begin
            case (rd_addr)
                3'd0:             m_rd = hist[1];
                3'd1, 3'd2, 3'd6: m_rd = m_out;
                3'd3, 3'd4, 3'd7: m_rd = m_dir;
                default:          m_rd = m_poff;
            endcase
            s_o = pick(a_we, a_addr, a_wdata, 1) | pick(b_we, b_addr, b_wdata, 1);
            c_o = pick(a_we, a_addr, a_wdata, 2) | pick(b_we, b_addr, b_wdata, 2);
            s_d = pick(a_we, a_addr, a_wdata, 3) | pick(b_we, b_addr, b_wdata, 3);
            c_d = pick(a_we, a_addr, a_wdata, 4) | pick(b_we, b_addr, b_wdata, 4);
            m_out = (m_out | s_o) & ~c_o;
            m_dir = (m_dir | s_d) & ~c_d;
            if (b_we && b_addr == 3'd5)      m_poff = b_wdata;
            else if (a_we && a_addr == 3'd5) m_poff = a_wdata;
            hist.push_front(pad_in);
        end
        while (hist.size() > 2) void'(hist.pop_back());
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R2/R3 pad_out", pad_out, m_out);
            check("R4 pad_oe", pad_oe, m_dir);
            check("R6 pad_pull_en", pad_pull_en, ~m_poff);
            check("R7 pad_pull_up", pad_pull_up, m_out);
            check("R9 rd_data", rd_data, m_rd);
        end
    end

    task automatic step(logic awe, logic [2:0] aa, logic [W-1:0] ad,
                        logic bwe, logic [2:0] ba, logic [W-1:0] bd,
                        logic [2:0] ra);
        a_we = awe; a_addr = aa; a_wdata = ad;
        b_we = bwe; b_addr = ba; b_wdata = bd;
        rd_addr = ra;
        @(negedge clk);
    endtask

    task automatic idle(logic [2:0] ra);
        step(1'b0, 3'd0, '0, 1'b0, 3'd0, '0, ra);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        check("R1 oe", pad_oe, '0);
        check("R1 out", pad_out, '0);
        check("R1 pull_en", pad_pull_en, '0);
        check("R1 rd", rd_data, '0);

        // R2 / R3
        step(1'b1, 3'd1, 32'hF0F0_00FF, 1'b0, 3'd0, '0, 3'd6);
        check("R2 set", pad_out, 32'hF0F0_00FF);
        step(1'b1, 3'd2, 32'h0000_000F, 1'b0, 3'd0, '0, 3'd6);
        check("R3 clear", pad_out, 32'hF0F0_00F0);
        check("R9 out readback", rd_data, 32'hF0F0_00FF);
        step(1'b1, 3'd1, 32'h0000_0000, 1'b0, 3'd0, '0, 3'd6);
        check("R2 zero bits no effect", pad_out, 32'hF0F0_00F0);

        // R4
        step(1'b0, 3'd0, '0, 1'b1, 3'd3, 32'h0000_FFFF, 3'd7);
        check("R4 dir set", pad_oe, 32'h0000_FFFF);
        step(1'b0, 3'd0, '0, 1'b1, 3'd4, 32'h0000_0F0F, 3'd7);
        check("R4 dir clear", pad_oe, 32'h0000_F0F0);

        // R5: cross-channel clash, clear wins
        step(1'b1, 3'd1, 32'h0000_FF00, 1'b1, 3'd2, 32'h0000_0F00, 3'd1);
        check("R5 out clash", pad_out, 32'hF0F0_F0F0);
        step(1'b1, 3'd3, 32'hFFFF_0000, 1'b1, 3'd4, 32'hFFFF_0000, 3'd3);
        check("R5 dir clash", pad_oe, 32'h0000_F0F0);

        // R6 / R7
        step(1'b1, 3'd5, 32'hFFFF_0000, 1'b0, 3'd0, '0, 3'd5);
        check("R6 pull word", pad_pull_en, 32'h0000_FFFF);
        step(1'b1, 3'd5, 32'h1111_1111, 1'b1, 3'd5, 32'h0000_00FF, 3'd5);
        check("R6 channel B wins", pad_pull_en, 32'hFFFF_FF00);
        step(1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0, 3'd0, '0, 3'd5);
        check("R7 pull follows data", pad_pull_up, '0);

        // R10: write to pin address ignored
        step(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, 3'd0, '0, 3'd0);
        check("R10 out", pad_out, '0);
        check("R10 oe", pad_oe, 32'h0000_F0F0);
        check("R10 pull", pad_pull_en, 32'hFFFF_FF00);

        // R8: synchroniser latency
        pad_in = 32'hA5A5_0001;
        idle(3'd0);
        idle(3'd0);
        check("R8 not yet", rd_data, '0);
        idle(3'd0);
        check("R8 pin level", rd_data, 32'hA5A5_0001);

        // Mixed traffic
        for (int i = 0; i < 200; i++) begin
            pad_in = $urandom;
            step($urandom_range(0, 1), 3'($urandom_range(0, 7)), $urandom,
                 $urandom_range(0, 1), 3'($urandom_range(0, 7)), $urandom,
                 3'($urandom_range(0, 7)));
        end
        idle(3'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        errors++;
        checks++;
        $display("FAIL watchdog R1..end actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule